// File: doc/BRIEF.md
# Watchdog and Interval Timer

This block is a combined watchdog and interval timer. It is driven by a free-running prescaler that divides the core clock by 2^PRE_W. Behind the prescaler sits an overflow counter that wraps after 2^CNT_W prescaler ticks. Software controls it through an 8-bit control register, written with a single byte write strobe. The three control bits can only be set. A write ORs each of them with its old value, and only the asynchronous reset clears them. Once the run bit is set, the timer counts until the next reset. Writing the run bit again while the timer is running services the watchdog: the overflow counter restarts, and the prescaler keeps its phase.

The mode bits decide what an overflow does. In interval mode it sends a one-cycle maskable interrupt pulse. In the first watchdog mode it sends a one-cycle non-maskable interrupt pulse. In the second watchdog mode it raises a reset request that stays high until reset. Every overflow also sets a request flag, which stays set until software clears it with a strobe. Arming watchdog mode while that flag is set produces an immediate non-maskable interrupt.

Top module: `wdt_core`

## Requirements
- R1: After reset, `rdata_o` reads 0x00, `req_flag_o` is 0, and `irq_o`, `nmi_o` and `rst_req_o` are all 0. Register bits 6, 5, 2, 1 and 0 always read 0, whatever value is written to them.
- R2: While the run bit (bit 7) is 0, nothing counts. Neither the request flag nor any output is raised.
- R3: A write with bit 7 = 1 clears the overflow counter and starts it counting. The prescaler is never cleared after reset and ticks once every 2^PRE_W cycles. The first overflow happens on the (2^CNT_W)-th tick that follows the write edge. The results of that overflow are visible in the cycle after that edge.
- R4: Bits 7, 4 and 3 are sticky. Writing 0 to any of them leaves it at 1, and only `rst_ni` clears them.
- R5: In interval mode (bit 4 = 0, bit 3 don't care), each overflow gives a one-cycle pulse on `irq_o`. Pulses repeat every 2^(PRE_W+CNT_W) cycles.
- R6: Each overflow sets `req_flag_o`. The flag stays set until a `flag_clr_i` strobe clears it. If an overflow and a clear strobe fall in the same cycle, the overflow wins.
- R7: A write with bit 7 = 1 while the timer is running restarts the overflow count from zero and leaves the mode bits unchanged.
- R8: With bit 4 = 1 and bit 3 = 0, an overflow gives a one-cycle `nmi_o` pulse and no `irq_o`.
- R9: With bit 4 = 1 and bit 3 = 1, an overflow raises `rst_req_o`, which stays high until `rst_ni` is asserted. In this mode no interrupt pulse is produced.
- R10: If a write sets bit 4 while it was 0 and `req_flag_o` is 1, `nmi_o` pulses in the cycle after the write, whatever bit 3 is. If the flag is 0, the same write produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Control register write strobe |
| wdata_i | input | 8 | Write data, ORed into the sticky bits |
| flag_clr_i | input | 1 | Clears the request flag |
| rdata_o | output | 8 | Control register read value |
| req_flag_o | output | 1 | Overflow request flag |
| irq_o | output | 1 | Maskable interval interrupt pulse |
| nmi_o | output | 1 | Non-maskable interrupt pulse |
| rst_req_o | output | 1 | Reset request, held until reset |

## Verification
Overflow results are registered. They appear one cycle after the edge on which the last count of the period meets a prescaler tick. The bench derives that edge from the write cycle and the prescaler phase: the phase is known because the prescaler has run freely from reset. The bench samples on the falling edge at exactly that cycle, and on every cycle before it checks that nothing fired early. The immediate arming interrupt and the register readback are due one cycle after the write edge, and the bench samples them on the first falling edge after the write. Restarts are swept over every prescaler phase, so a prescaler cleared on restart, or a count off by one, shows up as a shifted event.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_W   = 8;
  localparam int RUN_BIT = 7;
  localparam int SEL_BIT = 4;
  localparam int SUB_BIT = 3;

  typedef enum logic [1:0] {
    MODE_INTERVAL = 2'd0,
    MODE_NMI      = 2'd1,
    MODE_RESET    = 2'd2
  } wdt_mode_e;

  function automatic wdt_mode_e decode_mode(logic sel, logic sub);
    if (!sel)     return MODE_INTERVAL;
    else if (sub) return MODE_RESET;
    else          return MODE_NMI;
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (PRE_W == 0) begin : g_bypass
      assign tick_o = 1'b1;
    end else begin : g_div
      logic [PRE_W-1:0] pre_q;
      // free-running from reset; restart never touches it
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pre_q <= '0;
        else         pre_q <= pre_q + 1'b1;
      end
      assign tick_o = &pre_q;
    end
  endgenerate
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic ovf_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign ovf_o = en_i & (&cnt_q) & ~clr_i;
endmodule

// File: rtl/wdt_mode_reg.sv
module wdt_mode_reg
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             flag_i,
  output logic             run_o,
  output wdt_mode_e        mode_o,
  output logic             restart_o,
  output logic             arm_nmi_o,
  output logic [REG_W-1:0] rdata_o
);
  logic run_q, sel_q, sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      sel_q <= 1'b0;
      sub_q <= 1'b0;
    end else if (wr_en_i) begin
      run_q <= run_q | wdata_i[RUN_BIT];
      sel_q <= sel_q | wdata_i[SEL_BIT];
      sub_q <= sub_q | wdata_i[SUB_BIT];
    end
  end

  assign run_o     = run_q;
  assign mode_o    = decode_mode(sel_q, sub_q);
  assign restart_o = wr_en_i & wdata_i[RUN_BIT];
  // arming with a pending request fires at once
  assign arm_nmi_o = wr_en_i & wdata_i[SEL_BIT] & ~sel_q & flag_i;

  always_comb begin
    rdata_o          = '0;
    rdata_o[RUN_BIT] = run_q;
    rdata_o[SEL_BIT] = sel_q;
    rdata_o[SUB_BIT] = sub_q;
  end
endmodule

// File: rtl/wdt_event.sv
module wdt_event
  import wdt_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ovf_i,
  input  logic      arm_nmi_i,
  input  logic      flag_clr_i,
  input  wdt_mode_e mode_i,
  output logic      flag_o,
  output logic      irq_o,
  output logic      nmi_o,
  output logic      rst_req_o
);
  logic flag_q, irq_q, nmi_q, rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      nmi_q  <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      if (ovf_i)           flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
      irq_q <= ovf_i & (mode_i == MODE_INTERVAL);
      nmi_q <= (ovf_i & (mode_i == MODE_NMI)) | arm_nmi_i;
      rst_q <= rst_q | (ovf_i & (mode_i == MODE_RESET));
    end
  end

  assign flag_o    = flag_q;
  assign irq_o     = irq_q;
  assign nmi_o     = nmi_q;
  assign rst_req_o = rst_q;
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int PRE_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             flag_clr_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             req_flag_o,
  output logic             irq_o,
  output logic             nmi_o,
  output logic             rst_req_o
);
  logic      tick, run, restart, arm_nmi, ovf;
  wdt_mode_e mode;

  wdt_prescaler #(.PRE_W(PRE_W)) i_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  wdt_mode_reg i_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wdata_i   (wdata_i),
    .flag_i    (req_flag_o),
    .run_o     (run),
    .mode_o    (mode),
    .restart_o (restart),
    .arm_nmi_o (arm_nmi),
    .rdata_o   (rdata_o)
  );

  wdt_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run & tick),
    .clr_i  (restart),
    .ovf_o  (ovf)
  );

  wdt_event i_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ovf_i      (ovf),
    .arm_nmi_i  (arm_nmi),
    .flag_clr_i (flag_clr_i),
    .mode_i     (mode),
    .flag_o     (req_flag_o),
    .irq_o      (irq_o),
    .nmi_o      (nmi_o),
    .rst_req_o  (rst_req_o)
  );
endmodule

// File: rtl/wdt_core_chk.sv
module wdt_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       sel_wr_i,
  input logic [7:0] rdata_o,
  input logic       req_flag_o,
  input logic       irq_o,
  input logic       nmi_o,
  input logic       rst_req_o
);
  p_unused_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & 8'h67) == 8'h00);

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_o[7] |-> !(irq_o || nmi_o || rst_req_o || req_flag_o));

  p_run_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[7] |=> rdata_o[7]);

  p_sel_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[4] |=> rdata_o[4]);

  p_sub_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[3] |=> rdata_o[3]);

  p_irq_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_flag_with_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> req_flag_o);

  p_nmi_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o && !(wr_en_i && sel_wr_i) |=> !nmi_o);

  p_rst_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> rst_req_o);

  p_arm_nmi_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_wr_i && !rdata_o[4] && req_flag_o) |=> nmi_o);
endmodule

bind wdt_core wdt_core_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .sel_wr_i   (wdata_i[4]),
  .rdata_o    (rdata_o),
  .req_flag_o (req_flag_o),
  .irq_o      (irq_o),
  .nmi_o      (nmi_o),
  .rst_req_o  (rst_req_o)
);

// File: tb/test_wdt_core.sv
`timescale 1ns/1ps
module test_wdt_core;
  localparam int PRE_W = 2;
  localparam int CNT_W = 3;
  localparam int PRE   = 1 << PRE_W;
  localparam int TICKS = 1 << CNT_W;
  localparam int PER   = PRE * TICKS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       flag_clr = 1'b0;
  logic [7:0] rdata;
  logic       flag, irq, nmi, rst_req;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int last_w = 0;

  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;

  wdt_core #(.PRE_W(PRE_W), .CNT_W(CNT_W)) i_wdt_core (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wdata_i(wdata),
    .flag_clr_i(flag_clr), .rdata_o(rdata), .req_flag_o(flag),
    .irq_o(irq), .nmi_o(nmi), .rst_req_o(rst_req)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // overflow edge: first tick strictly after write edge w, then TICKS-1 more
  function automatic int due(int w);
    return ((w / PRE) + 1) * PRE + (TICKS - 1) * PRE;
  endfunction

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wdata = d;
    last_w = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0; wdata = 8'h00;
  endtask

  task automatic clr_flag();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
  endtask

  task automatic wait_evt(int o, string req, bit e_irq, bit e_nmi, bit e_rst);
    bit early = 0;
    while (cyc < o) begin
      if (irq || nmi || rst_req) early = 1;
      @(negedge clk);
    end
    chk(!early, req, "no event before due cycle", early, 0);
    chk(irq == e_irq && nmi == e_nmi && rst_req == e_rst, req, "event at due cycle",
        {irq, nmi, rst_req}, {e_irq, e_nmi, e_rst});
    @(negedge clk);
    chk(!irq && !nmi && rst_req == e_rst, req, "pulse one cycle", {irq, nmi, rst_req},
        {1'b0, 1'b0, e_rst});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int o;
    // session A: interval mode
    do_reset();
    @(negedge clk);
    chk(rdata == 8'h00 && !flag && !irq && !nmi && !rst_req, "R1", "reset state",
        {rdata, flag, irq, nmi, rst_req}, 0);
    wr(8'h67);
    chk(rdata == 8'h00, "R1", "unused bits read zero", rdata, 8'h00);
    begin
      bit any = 0;
      repeat (3 * PER) begin
        @(negedge clk);
        if (irq || nmi || rst_req || flag) any = 1;
      end
      chk(!any, "R2", "stopped timer quiet", any, 0);
    end
    wr(8'h88);
    chk(rdata == 8'h88, "R5", "bit3 accepted in interval mode", rdata, 8'h88);
    o = due(last_w);
    wait_evt(o, "R3", 1, 0, 0);
    chk(flag, "R6", "flag set by overflow", flag, 1);
    wait_evt(o + PER, "R5", 1, 0, 0);
    repeat (5) @(negedge clk);
    chk(flag, "R6", "flag held", flag, 1);
    clr_flag();
    chk(!flag, "R6", "flag cleared by strobe", flag, 0);
    wr(8'h00);
    chk(rdata == 8'h88, "R4", "sticky bits survive zero write", rdata, 8'h88);
    for (int ph = 0; ph < PRE; ph++) begin
      while ((cyc + 1) % PRE != ph) @(negedge clk);
      wr(8'h80);
      chk(rdata == 8'h88, "R7", "service keeps mode bits", rdata, 8'h88);
      wait_evt(due(last_w), "R3", 1, 0, 0);
    end
    for (int ph = 0; ph < PRE; ph++) begin
      wr(8'h80);
      repeat (PER / 2 + ph) @(negedge clk);
      wr(8'h80);
      wait_evt(due(last_w), "R7", 1, 0, 0);
    end

    // session B: NMI mode armed with flag clear
    do_reset();
    @(negedge clk);
    chk(rdata == 8'h00 && !flag, "R1", "reset clears sticky bits", rdata, 8'h00);
    wr(8'h80);
    wait_evt(due(last_w), "R5", 1, 0, 0);
    clr_flag();
    wr(8'h90);
    chk(!nmi, "R10", "no immediate nmi when flag clear", nmi, 0);
    chk(rdata == 8'h90, "R8", "nmi mode readback", rdata, 8'h90);
    wait_evt(due(last_w), "R8", 0, 1, 0);
    chk(flag, "R6", "flag set in nmi mode", flag, 1);

    // session C: arm with flag pending, then reset-request mode
    do_reset();
    wr(8'h80);
    wait_evt(due(last_w), "R5", 1, 0, 0);
    chk(flag, "R6", "flag pending before arming", flag, 1);
    wr(8'h98);
    chk(nmi, "R10", "immediate nmi on arming with flag set", nmi, 1);
    @(negedge clk);
    chk(!nmi, "R10", "immediate nmi one cycle", nmi, 0);
    clr_flag();
    wait_evt(due(last_w), "R9", 0, 0, 1);
    repeat (2 * PER) @(negedge clk);
    chk(rst_req && !irq && !nmi, "R9", "reset request held", {rst_req, irq, nmi}, 3'b100);
    wr(8'h80);
    chk(rst_req, "R9", "service does not drop reset request", rst_req, 1);
    do_reset();
    chk(!rst_req && rdata == 8'h00, "R9", "reset drops request", {rst_req, rdata}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule